// File: doc/BRIEF.md
# Memory-Mapped Button/LED Port with Two-Rectangle Pixel Overlay

This peripheral sits on a plain word-wide bus (address, write data, write strobe, read strobe, read data). Software reads a set of four direction buttons, drives eight LEDs, and programs the bounding boxes of two rectangles, one red and one green. Each rectangle takes two registers: one packs its horizontal edges, the other its vertical edges, each as two 16-bit halves.

A pixel port takes the current pixel column and row plus an active-video flag from an external video timing generator. It returns 4-bit red, green and blue intensities. Red shows inside the red box and green inside the green box; where the boxes overlap, green wins. A bus write to a box register moves the overlay on the next pixel that is shaded. The block does not make sync timing.

Top module: `gpio_rect_overlay`

## Requirements
- R1: After reset, the LED output is 0, all four rectangle registers read back as 0, read data is 0, and all three colour outputs are 0.
- R2: A write to 0x80000004 loads write-data bits [7:0] into the LED register. The LED output shows the value from the clock edge that takes the write. A read of 0x80000004 returns that value with bits [31:8] zero.
- R3: The read-only button register at 0x80000000 returns bit 0 = left, bit 1 = right, bit 2 = up, bit 3 = down, with bits [31:4] zero. Writes to this address change nothing.
- R4: The button inputs pass through two flip-flop stages. Read data captured at clock edge e shows the button levels sampled at edge e-2.
- R5: The rectangle registers are red-x at 0x80001000, red-y at 0x80001004, green-x at 0x80001008 and green-y at 0x8000100C. Each x register holds the left edge in [31:16] and the right edge in [15:0]. Each y register holds the top edge in [31:16] and the bottom edge in [15:0]. All 32 bits read back as written.
- R6: Read data is registered. It shows the selected register one cycle after the read strobe, and it is 0 in any cycle that follows a cycle with no read strobe.
- R7: A read of any other address returns 0. A write to any other address leaves the LED output and all registers unchanged.
- R8: A pixel is inside a rectangle when left <= x <= right and top <= y <= bottom, inclusive on every edge. A rectangle whose left edge is greater than its right edge covers no pixel. Inside the red box only, the output is red = 0xF, green = 0, blue = 0.
- R9: Inside the green box, the output is red = 0, green = 0xF, blue = 0. This holds even where the red box overlaps it. Blue is always 0.
- R10: The colour output is registered, one cycle after the pixel inputs. It is black (all zero) outside both boxes and whenever active video is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| key_in | input | 4 | Raw button levels (left, right, up, down) |
| led_out | output | 8 | LED drive |
| pix_x | input | 16 | Current pixel column |
| pix_y | input | 16 | Current pixel row |
| pix_active | input | 1 | Active-video flag |
| vid_r | output | 4 | Red intensity |
| vid_g | output | 4 | Green intensity |
| vid_b | output | 4 | Blue intensity |

## Verification
A write takes effect at the edge that accepts it. The LED output and the overlay reflect it from that edge on, and read data for a strobe is due at the next edge. The bench drives inputs on falling edges and samples one falling edge later, after exactly one rising edge. Button levels need two more edges. The bench changes the buttons while holding a read of the button register, and expects the old value at the first two samples and the new value at the third. The pixel colour is due one edge after its coordinates. The bench sweeps a 16 by 16 pixel field under several box layouts and checks every pixel at that sample point against a hit test it computes itself.

// File: rtl/gpov_pkg.sv
package gpov_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_KEY  = 2'd1,
      SEL_LED  = 2'd2,
      SEL_RECT = 2'd3
   } gpov_sel_e;

   localparam int unsigned RECT_COUNT = 4;
   localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/gpov_key_sync.sv
module gpov_key_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_in,
   output logic [WIDTH-1:0] sync_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpov_key_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= raw_in;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpov_regbank.sv
module gpov_regbank
   import gpov_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned KEY_W     = 4,
   parameter int unsigned LED_W     = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] LED_ADDR  = 32'h8000_0004,
   parameter logic [ADDR_W-1:0] RECT_BASE = 32'h8000_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic [KEY_W-1:0]  key_sync,
   output logic [DATA_W-1:0] rdata,
   output logic [LED_W-1:0]  led,
   output logic [DATA_W-1:0] rect_reg [RECT_COUNT]
);
   localparam int unsigned IDX_W = $clog2(RECT_COUNT);

   gpov_sel_e        sel;
   logic [IDX_W-1:0] rect_idx;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;
   logic [LED_W-1:0]  led_q;
   logic [DATA_W-1:0] rect_q [RECT_COUNT];

   always_comb begin
      sel      = SEL_NONE;
      rect_idx = '0;
      if (addr == KEY_ADDR) sel = SEL_KEY;
      else if (addr == LED_ADDR) sel = SEL_LED;
      else begin
         for (int i = 0; i < RECT_COUNT; i++) begin
            if (addr == RECT_BASE + ADDR_W'(WORD_BYTES * i)) begin
               sel      = SEL_RECT;
               rect_idx = IDX_W'(i);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          led_q <= '0;
      else if (wr_en && sel == SEL_LED)    led_q <= wdata[LED_W-1:0];
   end

   generate
      for (genvar r = 0; r < RECT_COUNT; r++) begin : g_rect
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rect_q[r] <= '0;
            else if (wr_en && sel == SEL_RECT && rect_idx == IDX_W'(r))
               rect_q[r] <= wdata;
         end
         assign rect_reg[r] = rect_q[r];
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_KEY:  rd_mux = {{(DATA_W-KEY_W){1'b0}}, key_sync};
         SEL_LED:  rd_mux = {{(DATA_W-LED_W){1'b0}}, led_q};
         SEL_RECT: rd_mux = rect_q[rect_idx];
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rd_en ? rd_mux : '0;
   end

   assign rdata = rdata_q;
   assign led   = led_q;
endmodule

// File: rtl/gpov_rect_hit.sv
module gpov_rect_hit #(
   parameter int unsigned COORD_W = 16
) (
   input  logic [2*COORD_W-1:0] x_edges,
   input  logic [2*COORD_W-1:0] y_edges,
   input  logic [COORD_W-1:0]   px,
   input  logic [COORD_W-1:0]   py,
   output logic                 hit
);
   logic [COORD_W-1:0] lo_x, hi_x, lo_y, hi_y;

   assign lo_x = x_edges[2*COORD_W-1:COORD_W];
   assign hi_x = x_edges[COORD_W-1:0];
   assign lo_y = y_edges[2*COORD_W-1:COORD_W];
   assign hi_y = y_edges[COORD_W-1:0];

   assign hit = (px >= lo_x) && (px <= hi_x) && (py >= lo_y) && (py <= hi_y);
endmodule

// File: rtl/gpov_shader.sv
module gpov_shader
   import gpov_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned COORD_W      = 16,
   parameter int unsigned COLOR_W      = 4,
   parameter bit          GREEN_ON_TOP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DATA_W-1:0]  rect_reg [RECT_COUNT],
   input  logic [COORD_W-1:0] px,
   input  logic [COORD_W-1:0] py,
   input  logic               active,
   output logic [COLOR_W-1:0] r_out,
   output logic [COLOR_W-1:0] g_out,
   output logic [COLOR_W-1:0] b_out
);
   localparam int unsigned BOXES = RECT_COUNT / 2;

   logic [BOXES-1:0] hit;
   logic show_r, show_g;
   logic [COLOR_W-1:0] r_q, g_q;

   generate
      for (genvar b = 0; b < BOXES; b++) begin : g_box
         gpov_rect_hit #(.COORD_W(COORD_W)) u_hit (
            .x_edges (rect_reg[2*b][2*COORD_W-1:0]),
            .y_edges (rect_reg[2*b+1][2*COORD_W-1:0]),
            .px      (px),
            .py      (py),
            .hit     (hit[b])
         );
      end

      if (GREEN_ON_TOP) begin : g_green_top
         assign show_g = hit[1];
         assign show_r = hit[0] & ~hit[1];
      end else begin : g_red_top
         assign show_r = hit[0];
         assign show_g = hit[1] & ~hit[0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q <= '0;
         g_q <= '0;
      end else begin
         r_q <= {COLOR_W{active & show_r}};
         g_q <= {COLOR_W{active & show_g}};
      end
   end

   assign r_out = r_q;
   assign g_out = g_q;
   assign b_out = '0;
endmodule

// File: rtl/gpio_rect_overlay.sv
module gpio_rect_overlay
   import gpov_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned KEY_W        = 4,
   parameter int unsigned LED_W        = 8,
   parameter int unsigned COORD_W      = 16,
   parameter int unsigned COLOR_W      = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          GREEN_ON_TOP = 1'b1,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] LED_ADDR  = 32'h8000_0004,
   parameter logic [ADDR_W-1:0] RECT_BASE = 32'h8000_1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr_en,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_rd_en,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [KEY_W-1:0]   key_in,
   output logic [LED_W-1:0]   led_out,
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic               pix_active,
   output logic [COLOR_W-1:0] vid_r,
   output logic [COLOR_W-1:0] vid_g,
   output logic [COLOR_W-1:0] vid_b
);
   generate
      if (DATA_W != 2 * COORD_W) begin : g_bad_pack
         $error("gpio_rect_overlay: DATA_W must equal 2*COORD_W");
      end
      if (KEY_W > DATA_W || LED_W > DATA_W) begin : g_bad_io
         $error("gpio_rect_overlay: KEY_W and LED_W must fit in DATA_W");
      end
      if (COLOR_W < 1) begin : g_bad_color
         $error("gpio_rect_overlay: COLOR_W must be positive");
      end
   endgenerate

   logic [KEY_W-1:0]  key_sync;
   logic [DATA_W-1:0] rect_reg [RECT_COUNT];

   gpov_key_sync #(.WIDTH(KEY_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (key_in),
      .sync_out (key_sync)
   );

   gpov_regbank #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .KEY_W     (KEY_W),
      .LED_W     (LED_W),
      .KEY_ADDR  (KEY_ADDR),
      .LED_ADDR  (LED_ADDR),
      .RECT_BASE (RECT_BASE)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wr_en    (bus_wr_en),
      .wdata    (bus_wdata),
      .rd_en    (bus_rd_en),
      .key_sync (key_sync),
      .rdata    (bus_rdata),
      .led      (led_out),
      .rect_reg (rect_reg)
   );

   gpov_shader #(
      .DATA_W       (DATA_W),
      .COORD_W      (COORD_W),
      .COLOR_W      (COLOR_W),
      .GREEN_ON_TOP (GREEN_ON_TOP)
   ) u_shade (
      .clk      (clk),
      .rst_n    (rst_n),
      .rect_reg (rect_reg),
      .px       (pix_x),
      .py       (pix_y),
      .active   (pix_active),
      .r_out    (vid_r),
      .g_out    (vid_g),
      .b_out    (vid_b)
   );
endmodule

// File: rtl/gpio_rect_overlay_chk.sv
module gpio_rect_overlay_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned KEY_W   = 4,
   parameter int unsigned LED_W   = 8,
   parameter int unsigned COLOR_W = 4,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] LED_ADDR  = 32'h8000_0004,
   parameter logic [ADDR_W-1:0] RECT_BASE = 32'h8000_1000
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_wr_en,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic               bus_rd_en,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [KEY_W-1:0]   key_in,
   input logic [LED_W-1:0]   led_out,
   input logic               pix_active,
   input logic [COLOR_W-1:0] vid_r,
   input logic [COLOR_W-1:0] vid_g,
   input logic [COLOR_W-1:0] vid_b
);
   logic [1:0] since_rst;
   logic       mapped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assign mapped = (bus_addr == KEY_ADDR) || (bus_addr == LED_ADDR) ||
                   (bus_addr >= RECT_BASE && bus_addr <= RECT_BASE + ADDR_W'(12) &&
                    bus_addr[1:0] == 2'b00);

   AST_LED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && bus_addr == LED_ADDR) |=> (led_out == $past(bus_wdata[LED_W-1:0]))); // R2

   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr_en && bus_addr == LED_ADDR) |=> $stable(led_out)); // R7

   AST_KEY_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && bus_rd_en && bus_addr == KEY_ADDR) |=>
         (bus_rdata == {{(DATA_W-KEY_W){1'b0}}, $past(key_in, 3)})); // R4

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && !mapped) |=> (bus_rdata == '0)); // R7

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |=> (bus_rdata == '0)); // R6

   AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_active |=> (vid_r == '0 && vid_g == '0)); // R10

   AST_ONE_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
      !(vid_r != '0 && vid_g != '0)); // R9

   AST_NO_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
      vid_b == '0); // R9
endmodule

bind gpio_rect_overlay gpio_rect_overlay_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .KEY_W     (KEY_W),
   .LED_W     (LED_W),
   .COLOR_W   (COLOR_W),
   .KEY_ADDR  (KEY_ADDR),
   .LED_ADDR  (LED_ADDR),
   .RECT_BASE (RECT_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr_en  (bus_wr_en),
   .bus_wdata  (bus_wdata),
   .bus_rd_en  (bus_rd_en),
   .bus_rdata  (bus_rdata),
   .key_in     (key_in),
   .led_out    (led_out),
   .pix_active (pix_active),
   .vid_r      (vid_r),
   .vid_g      (vid_g),
   .vid_b      (vid_b)
);

// File: tb/gpio_rect_overlay_test.sv
module gpio_rect_overlay_test;
   localparam logic [31:0] A_KEY = 32'h8000_0000;
   localparam logic [31:0] A_LED = 32'h8000_0004;
   localparam logic [31:0] A_RX  = 32'h8000_1000;
   localparam logic [31:0] A_RY  = 32'h8000_1004;
   localparam logic [31:0] A_GX  = 32'h8000_1008;
   localparam logic [31:0] A_GY  = 32'h8000_100C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        bus_wr_en = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd_en = 1'b0;
   logic [31:0] bus_rdata;
   logic [3:0]  key_in = '0;
   logic [7:0]  led_out;
   logic [15:0] pix_x = '0;
   logic [15:0] pix_y = '0;
   logic        pix_active = 1'b0;
   logic [3:0]  vid_r, vid_g, vid_b;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [31:0] m_rx, m_ry, m_gx, m_gy;

   always #4 clk = ~clk;

   gpio_rect_overlay uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
      .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
      .key_in(key_in), .led_out(led_out), .pix_x(pix_x), .pix_y(pix_y),
      .pix_active(pix_active), .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd_en = 1'b1;
      @(negedge clk);
      bus_rd_en = 1'b0;
      d = bus_rdata;
   endtask

   function automatic bit inside_box(input logic [31:0] xr, input logic [31:0] yr,
                                     input int x, input int y);
      return (x >= int'(xr[31:16])) && (x <= int'(xr[15:0])) &&
             (y >= int'(yr[31:16])) && (y <= int'(yr[15:0]));
   endfunction

   task automatic set_boxes(input logic [31:0] rx, input logic [31:0] ry,
                            input logic [31:0] gx, input logic [31:0] gy);
      bus_write(A_RX, rx); bus_write(A_RY, ry);
      bus_write(A_GX, gx); bus_write(A_GY, gy);
      m_rx = rx; m_ry = ry; m_gx = gx; m_gy = gy;
   endtask

   task automatic sweep(input bit act, input string tag);
      for (int y = 0; y < 16; y++) begin
         for (int x = 0; x < 16; x++) begin
            logic [11:0] exp;
            bit in_r, in_g;
            @(negedge clk);
            pix_x = 16'(x); pix_y = 16'(y); pix_active = act;
            in_r = inside_box(m_rx, m_ry, x, y);
            in_g = inside_box(m_gx, m_gy, x, y);
            if (!act)      exp = 12'h000;
            else if (in_g) exp = 12'h0F0;
            else if (in_r) exp = 12'hF00;
            else           exp = 12'h000;
            @(negedge clk);
            check(tag, {20'h0, vid_r, vid_g, vid_b}, {20'h0, exp});
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check("R1 led", {24'h0, led_out}, 32'h0);
      check("R1 rdata", bus_rdata, 32'h0);
      check("R1 colour", {20'h0, vid_r, vid_g, vid_b}, 32'h0);
      bus_read(A_RX, d); check("R1 red-x", d, 32'h0);
      bus_read(A_RY, d); check("R1 red-y", d, 32'h0);
      bus_read(A_GX, d); check("R1 green-x", d, 32'h0);
      bus_read(A_GY, d); check("R1 green-y", d, 32'h0);

      // R2 LED register
      @(negedge clk);
      bus_addr = A_LED; bus_wdata = 32'hFFFF_FFA5; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
      check("R2 led after one edge", {24'h0, led_out}, 32'hA5);
      bus_read(A_LED, d); check("R2 led readback", d, 32'h0000_00A5);

      // R6 read latency and idle-zero
      @(negedge clk);
      bus_addr = A_LED; bus_rd_en = 1'b1;
      @(negedge clk);
      check("R6 data one cycle after strobe", bus_rdata, 32'hA5);
      bus_rd_en = 1'b0;
      @(negedge clk);
      check("R6 zero after idle cycle", bus_rdata, 32'h0);

      // R5 rectangle readback
      bus_write(A_RX, 32'h1234_ABCD); bus_write(A_RY, 32'hFFFF_0001);
      bus_write(A_GX, 32'h8000_7FFF); bus_write(A_GY, 32'h0F0F_F0F0);
      bus_read(A_RX, d); check("R5 red-x", d, 32'h1234_ABCD);
      bus_read(A_RY, d); check("R5 red-y", d, 32'hFFFF_0001);
      bus_read(A_GX, d); check("R5 green-x", d, 32'h8000_7FFF);
      bus_read(A_GY, d); check("R5 green-y", d, 32'h0F0F_F0F0);

      // R7 unmapped accesses
      bus_write(32'h8000_1010, 32'hDEAD_BEEF);
      bus_write(32'h8000_0008, 32'h0000_005A);
      bus_write(32'h8000_1002, 32'h5555_5555);
      bus_read(32'h8000_1010, d); check("R7 unmapped read", d, 32'h0);
      bus_read(32'h8000_0008, d); check("R7 unmapped read", d, 32'h0);
      check("R7 led untouched", {24'h0, led_out}, 32'hA5);
      bus_read(A_RX, d); check("R7 red-x untouched", d, 32'h1234_ABCD);
      bus_read(A_GY, d); check("R7 green-y untouched", d, 32'h0F0F_F0F0);

      // R3 button register, all patterns
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         key_in = 4'(k);
         repeat (3) @(negedge clk);
         bus_read(A_KEY, d);
         check("R3 key value", d, 32'(k));
      end
      key_in = 4'b0110;
      repeat (4) @(negedge clk);
      bus_write(A_KEY, 32'hFFFF_FFFF);
      bus_read(A_KEY, d); check("R3 key write ignored", d, 32'h6);

      // R4 two-stage synchronizer latency
      @(negedge clk);
      bus_addr = A_KEY; bus_rd_en = 1'b1; key_in = 4'b1001;
      @(negedge clk); check("R4 first edge old", bus_rdata, 32'h6);
      @(negedge clk); check("R4 second edge old", bus_rdata, 32'h6);
      @(negedge clk); check("R4 third edge new", bus_rdata, 32'h9);
      bus_rd_en = 1'b0;

      // R8 R9 R10 overlapping boxes
      set_boxes({16'd2, 16'd9}, {16'd3, 16'd7}, {16'd6, 16'd12}, {16'd5, 16'd10});
      sweep(1'b1, "R9 overlap sweep");
      // R8 single-pixel red, empty green (left > right)
      set_boxes({16'd5, 16'd5}, {16'd5, 16'd5}, {16'd10, 16'd4}, {16'd0, 16'd15});
      sweep(1'b1, "R8 single pixel sweep");
      // R8 box touching field edges, green disjoint
      set_boxes({16'd0, 16'd15}, {16'd0, 16'd3}, {16'd0, 16'd0}, {16'd15, 16'd15});
      sweep(1'b1, "R8 edge sweep");
      // R10 blanking
      sweep(1'b0, "R10 blank sweep");

      // R10 overlay follows a bus write on the next pixel
      @(negedge clk);
      pix_x = 16'd1; pix_y = 16'd1; pix_active = 1'b1;
      bus_addr = A_GX; bus_wdata = {16'd1, 16'd1}; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_addr = A_GY; bus_wdata = {16'd1, 16'd1};
      @(negedge clk);
      bus_wr_en = 1'b0;
      @(negedge clk);
      check("R10 overlay after write", {20'h0, vid_r, vid_g, vid_b}, 32'h0F0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule